// File: doc/BRIEF.md
# Configurable Logic-Array Macrocell with Carry Chain

This block is a single programmable macrocell for a product-term logic array. It takes up to `NPT` product-term bits, ORs together the ones its configuration enables, and feeds that sum into an XOR stage. The XOR stage has a selectable second operand: constant low passes the sum through, constant high inverts it, the register's own output turns the D register into a toggle register, and the local carry builds arithmetic and parity functions. The XOR result either leaves the cell directly or is captured by a register and presented from there.

The register has a programmable clock. It can use any of four global clocks or a product-term clock, on either edge. It also has an asynchronous set and an asynchronous clear. Each of these is driven by one of two control product terms or tied off, and each control term can be inverted. A carry mux picks one of two carry product terms according to the incoming carry. That incoming carry is first gated by a configuration bit so the chain can be split at any cell. The mux output goes both to the next cell and to the local XOR operand.

The configuration word is static. It is copied into the cell on rising edges of global clock 0 while `rst_n` is low, and it is ignored at all other times. The register has no state machine of its own; its only state is the stored bit, which goes low when reset is applied.

Top module: `mc_macrocell`

## Requirements
- R1: The sum term is high exactly when at least one product-term input whose enable bit is set is high. The enable bits sit in configuration bits [NPT+13:14], with bit 14+i enabling `pt[i]`. Disabled inputs have no effect.
- R2: Configuration bit 13 selects the output. When it is 1, `mc_out` is the combinational XOR result. When it is 0, `mc_out` is the register output, which changes only on the selected clock edge or on an asynchronous set or clear.
- R3: Configuration bits [12:10] select the register clock. Values 0 to 3 pick `gclk[0]` to `gclk[3]`, and values 4 to 7 pick `ptclk`. Edges on clocks that are not selected do not change the register.
- R4: Configuration bit 9 picks the capture edge: 0 for rising, 1 for falling. Captures happen only on that edge of the selected clock.
- R5: The asynchronous set selector is configuration bits [8:7] and the clear selector is bits [6:5]. For each one, code 1 uses control term `prc[0]`, code 2 uses `prc[1]`, and codes 0 and 3 tie it low. An active set drives the register to 1 and an active clear drives it to 0, without any clock edge. The register keeps its value after the control goes away.
- R6: Configuration bits [4:3] invert `prc[1]` and `prc[0]` respectively before they reach the selectors.
- R7: When set and clear are active together, the register goes to 0.
- R8: Configuration bits [1:0] pick the XOR operand. Code 0 is constant 0 (pass the sum), code 1 is constant 1 (invert the sum), code 2 is the register output, and code 3 is the local carry.
- R9: With operand code 2 in registered mode, a high sum makes the register toggle on every capture edge, and a low sum makes it hold.
- R10: With configuration bit 2 set, `cout` equals `cpt[1]` when `cin` is 1 and `cpt[0]` when `cin` is 0.
- R11: With configuration bit 2 clear, `cin` is ignored and `cout` equals `cpt[0]`.
- R12: Operand code 3 XORs the sum with the same carry value that drives `cout`.
- R13: While `rst_n` is high, changes on `cfg_i` have no effect. A new word takes effect only after it has been applied across a rising edge of `gclk[0]` with `rst_n` low.
- R14: While `rst_n` is low, the register is held at 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset; clears the register and loads the configuration |
| gclk | input | 4 | Global clocks; `gclk[0]` also loads configuration |
| ptclk | input | 1 | Clock formed by a product term |
| pt | input | NPT | Product-term inputs to the sum |
| cpt | input | 2 | Carry product terms |
| prc | input | 2 | Set/clear control product terms |
| cin | input | 1 | Carry from the previous cell |
| cfg_i | input | NPT+14 | Static configuration word |
| mc_out | output | 1 | Cell output (registered or combinational) |
| cout | output | 1 | Carry to the next cell |

## Verification
The hardest situation to reach from the ports is a register update caused by something other than the free-running clock. This covers an asynchronous set or clear arriving between edges, set and clear active together, and a capture on the falling edge of a clock that is not the bench clock. To get there, the stimulus selects `gclk[1]` or `ptclk` as the register clock and leaves it idle. The control terms are then raised and dropped by hand, and the output is read a moment later, with no edge in between. For the clock tests, the selected clock's edges are pulsed one at a time while the other clocks keep running, so each capture can be traced to exactly one edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CTL_W = 14;

    typedef enum logic [1:0] {
        XS_ZERO  = 2'd0,
        XS_ONE   = 2'd1,
        XS_FB    = 2'd2,
        XS_CARRY = 2'd3
    } xsel_e;

    typedef enum logic [1:0] {
        AR_NONE = 2'd0,
        AR_PRC0 = 2'd1,
        AR_PRC1 = 2'd2,
        AR_OFF  = 2'd3
    } arsel_e;

    typedef struct packed {
        logic       out_comb;
        logic [2:0] clk_src;
        logic       clk_fall;
        arsel_e     pre_sel;
        arsel_e     clr_sel;
        logic [1:0] prc_inv;
        logic       carry_en;
        xsel_e      xsel;
    } ctl_cfg_t;

endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
    parameter int NPT = 16
) (
    input  logic [NPT-1:0] pt_i,
    input  logic [NPT-1:0] en_i,
    output logic           sum_o
);
    logic [NPT-1:0] term;

    for (genvar i = 0; i < NPT; i++) begin : g_term
        assign term[i] = pt_i[i] & en_i[i];
    end

    assign sum_o = |term;
endmodule

// File: rtl/mc_carry.sv
module mc_carry (
    input  logic       cin_i,
    input  logic       seg_en_i,
    input  logic [1:0] cpt_i,
    output logic       carry_o
);
    logic cin_gated;

    assign cin_gated = cin_i & seg_en_i;

    always_comb begin
        unique case (cin_gated)
            1'b1:    carry_o = cpt_i[1];
            default: carry_o = cpt_i[0];
        endcase
    end
endmodule

// File: rtl/mc_arctl.sv
module mc_arctl
    import mc_pkg::*;
(
    input  logic [1:0] prc_i,
    input  logic [1:0] inv_i,
    input  arsel_e     pre_sel_i,
    input  arsel_e     clr_sel_i,
    output logic       set_o,
    output logic       clr_o
);
    logic [1:0] prc_eff;

    for (genvar i = 0; i < 2; i++) begin : g_inv
        assign prc_eff[i] = prc_i[i] ^ inv_i[i];
    end

    function automatic logic pick(input arsel_e s, input logic [1:0] p);
        logic r;
        unique case (s)
            AR_PRC0: r = p[0];
            AR_PRC1: r = p[1];
            AR_NONE: r = 1'b0;
            AR_OFF:  r = 1'b0;
        endcase
        return r;
    endfunction

    always_comb begin
        set_o = pick(pre_sel_i, prc_eff);
        clr_o = pick(clr_sel_i, prc_eff);
    end
endmodule

// File: rtl/mc_dreg.sv
module mc_dreg (
    input  logic clk_i,
    input  logic fall_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic q_rise;
    logic q_fall;

    always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
        if (clr_i)      q_rise <= 1'b0;
        else if (set_i) q_rise <= 1'b1;
        else            q_rise <= d_i;
    end

    always_ff @(negedge clk_i or posedge clr_i or posedge set_i) begin
        if (clr_i)      q_fall <= 1'b0;
        else if (set_i) q_fall <= 1'b1;
        else            q_fall <= d_i;
    end

    assign q_o = fall_i ? q_fall : q_rise;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int NPT = 16,
    localparam int CFG_W = NPT + CTL_W
) (
    input  logic             rst_n,
    input  logic [3:0]       gclk,
    input  logic             ptclk,
    input  logic [NPT-1:0]   pt,
    input  logic [1:0]       cpt,
    input  logic [1:0]       prc,
    input  logic             cin,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             mc_out,
    output logic             cout
);
    logic [CFG_W-1:0] cfg_q;
    ctl_cfg_t         ctl;
    logic [NPT-1:0]   pt_en;
    logic             sum;
    logic             carry;
    logic             set_pt;
    logic             clr_pt;
    logic             clr_all;
    logic             sel_clk;
    logic             q;
    logic             xop;
    logic             xres;

    // configuration shadow, loaded only while reset is held
    always_ff @(posedge gclk[0]) begin
        if (!rst_n) cfg_q <= cfg_i;
    end

    assign ctl   = ctl_cfg_t'(cfg_q[CTL_W-1:0]);
    assign pt_en = cfg_q[CFG_W-1:CTL_W];

    mc_sum #(.NPT(NPT)) u_sum (
        .pt_i (pt),
        .en_i (pt_en),
        .sum_o(sum)
    );

    mc_carry u_carry (
        .cin_i   (cin),
        .seg_en_i(ctl.carry_en),
        .cpt_i   (cpt),
        .carry_o (carry)
    );

    mc_arctl u_arctl (
        .prc_i    (prc),
        .inv_i    (ctl.prc_inv),
        .pre_sel_i(ctl.pre_sel),
        .clr_sel_i(ctl.clr_sel),
        .set_o    (set_pt),
        .clr_o    (clr_pt)
    );

    always_comb begin
        if (ctl.clk_src[2]) sel_clk = ptclk;
        else                sel_clk = gclk[ctl.clk_src[1:0]];
    end

    always_comb begin
        unique case (ctl.xsel)
            XS_ZERO:  xop = 1'b0;
            XS_ONE:   xop = 1'b1;
            XS_FB:    xop = q;
            XS_CARRY: xop = carry;
        endcase
        xres = sum ^ xop;
    end

    assign clr_all = clr_pt | ~rst_n;

    mc_dreg u_reg (
        .clk_i (sel_clk),
        .fall_i(ctl.clk_fall),
        .set_i (set_pt),
        .clr_i (clr_all),
        .d_i   (xres),
        .q_o   (q)
    );

    assign mc_out = ctl.out_comb ? xres : q;
    assign cout   = carry;

    // R7
    clr_prio_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        ($past(rst_n) && clr_pt && $past(clr_pt)) |-> (q == 1'b0));

    // R5
    set_hold_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        ($past(rst_n) && set_pt && !clr_pt && $past(set_pt && !clr_pt)) |-> (q == 1'b1));

    // R2
    capture_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        ($past(rst_n) && ctl.clk_src == 3'd0 && !ctl.clk_fall
         && !(set_pt | clr_pt) && !$past(set_pt | clr_pt)) |-> (q == $past(xres)));

    // R10
    carry_fwd_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (ctl.carry_en && cin) |-> (cout == cpt[1]));

    // R11
    carry_cut_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (!ctl.carry_en) |-> (cout == cpt[0]));
endmodule

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;
    localparam int NPT = 16;
    localparam int CFG_W = NPT + 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:1]       g_hi = '0;
    logic [3:0]       gclk;
    logic             ptclk = 1'b0;
    logic [NPT-1:0]   pt = '0;
    logic [1:0]       cpt = '0;
    logic [1:0]       prc = '0;
    logic             cin = 1'b0;
    logic [CFG_W-1:0] cfg_i = '0;
    logic             mc_out;
    logic             cout;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;
    assign gclk = {g_hi, clk};

    mc_macrocell #(.NPT(NPT)) u0 (
        .rst_n(rst_n), .gclk(gclk), .ptclk(ptclk), .pt(pt), .cpt(cpt),
        .prc(prc), .cin(cin), .cfg_i(cfg_i), .mc_out(mc_out), .cout(cout)
    );

    function automatic logic [CFG_W-1:0] mk(
        input logic [15:0] en, input logic oc, input logic [2:0] cs,
        input logic cf, input logic [1:0] ps, input logic [1:0] rs,
        input logic [1:0] inv, input logic ce, input logic [1:0] xs);
        return {en, oc, cs, cf, ps, rs, inv, ce, xs};
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic load(input logic [CFG_W-1:0] w, input logic [1:0] prc_idle);
        @(negedge clk);
        rst_n = 1'b0; cfg_i = w; prc = prc_idle;
        pt = '0; cpt = '0; cin = 1'b0; g_hi = '0; ptclk = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_sum;
        load(mk(16'h00F0, 1, 0, 0, 0, 0, 0, 0, 0), 2'b00);
        chk("R14 reset", mc_out, 1'b0);
        pt = 16'h0F0F; #1 chk("R1 disabled only", mc_out, 1'b0);
        pt = 16'h0010; #1 chk("R1 one enabled", mc_out, 1'b1);
        pt = 16'h8000; #1 chk("R1 top disabled", mc_out, 1'b0);
        pt = 16'h00F0; #1 chk("R1 all enabled", mc_out, 1'b1);
    endtask

    task automatic t_outmux;
        load(mk(16'h0001, 0, 0, 0, 0, 0, 0, 0, 0), 2'b00);
        pt = 16'h0001; #1 chk("R2 before edge", mc_out, 1'b0);
        @(negedge clk); chk("R2 after edge", mc_out, 1'b1);
        pt = '0; #1 chk("R2 holds", mc_out, 1'b1);
        @(negedge clk); chk("R2 recapture", mc_out, 1'b0);
    endtask

    task automatic t_clksrc;
        load(mk(16'hFFFF, 0, 3'd2, 0, 0, 0, 0, 0, 0), 2'b00);
        pt = 16'h0001;
        repeat (3) @(negedge clk);
        chk("R3 other clock ignored", mc_out, 1'b0);
        g_hi[2] = 1'b1; #2 chk("R3 gclk2 capture", mc_out, 1'b1);
        g_hi[2] = 1'b0; pt = '0; #2;
        g_hi[3] = 1'b1; #2 g_hi[3] = 1'b0;
        ptclk = 1'b1; #2 ptclk = 1'b0; #1
        chk("R3 gclk3/ptclk ignored", mc_out, 1'b1);
        g_hi[2] = 1'b1; #2 chk("R3 gclk2 second", mc_out, 1'b0);
        g_hi[2] = 1'b0;
    endtask

    task automatic t_edge;
        load(mk(16'hFFFF, 0, 3'd4, 1, 0, 0, 0, 0, 2'd1), 2'b00);
        ptclk = 1'b1; #2 chk("R4 rise ignored", mc_out, 1'b0);
        ptclk = 1'b0; #2 chk("R4 fall capture", mc_out, 1'b1);
        load(mk(16'hFFFF, 0, 3'd4, 0, 0, 0, 0, 0, 2'd1), 2'b00);
        ptclk = 1'b1; #2 chk("R4 rise capture", mc_out, 1'b1);
        pt = 16'h0002; #1;
        ptclk = 1'b0; #2 chk("R4 fall ignored", mc_out, 1'b1);
    endtask

    task automatic t_async;
        load(mk(16'hFFFF, 0, 3'd1, 0, 2'd1, 2'd2, 0, 0, 0), 2'b00);
        prc = 2'b01; #1 chk("R5 set no clock", mc_out, 1'b1);
        prc = 2'b00; #1 chk("R5 set holds", mc_out, 1'b1);
        prc = 2'b10; #1 chk("R5 clear no clock", mc_out, 1'b0);
        prc = 2'b00; #1;
        prc = 2'b01; #1 chk("R5 set again", mc_out, 1'b1);
        prc = 2'b11; #1 chk("R7 clear wins", mc_out, 1'b0);
        prc = 2'b10; #1 chk("R7 after set drop", mc_out, 1'b0);
        prc = 2'b00; #1 chk("R7 idle", mc_out, 1'b0);
        load(mk(16'hFFFF, 0, 3'd1, 0, 2'd0, 2'd0, 0, 0, 0), 2'b00);
        prc = 2'b11; #1 chk("R5 tied off", mc_out, 1'b0);
        prc = 2'b00;
    endtask

    task automatic t_inv;
        load(mk(16'hFFFF, 0, 3'd1, 0, 2'd1, 2'd0, 2'b01, 0, 0), 2'b01);
        chk("R6 high input inactive", mc_out, 1'b0);
        prc = 2'b00; #1 chk("R6 low input sets", mc_out, 1'b1);
        prc = 2'b01; #1 chk("R6 released holds", mc_out, 1'b1);
    endtask

    task automatic t_xor;
        load(mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 2'd1), 2'b00);
        chk("R8 invert zero", mc_out, 1'b1);
        pt = 16'h0004; #1 chk("R8 invert one", mc_out, 1'b0);
    endtask

    task automatic t_toggle;
        load(mk(16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 2'd2), 2'b00);
        pt = 16'h0001;
        @(negedge clk); chk("R9 toggle 1", mc_out, 1'b1);
        @(negedge clk); chk("R9 toggle 2", mc_out, 1'b0);
        @(negedge clk); chk("R9 toggle 3", mc_out, 1'b1);
        pt = '0;
        @(negedge clk); chk("R9 hold 1", mc_out, 1'b1);
        @(negedge clk); chk("R9 hold 2", mc_out, 1'b1);
        rst_n = 1'b0; #1 chk("R14 async clear", mc_out, 1'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_carry;
        load(mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 1, 0), 2'b00);
        cpt = 2'b10; cin = 1'b0; #1 chk("R10 cin0", cout, 1'b0);
        cin = 1'b1; #1 chk("R10 cin1", cout, 1'b1);
        cpt = 2'b01; #1 chk("R10 cin1 cpt1 low", cout, 1'b0);
        cin = 1'b0; #1 chk("R10 cin0 cpt0 high", cout, 1'b1);
        load(mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 0), 2'b00);
        cpt = 2'b10; cin = 1'b1; #1 chk("R11 cut", cout, 1'b0);
        cpt = 2'b01; #1 chk("R11 cut cpt0", cout, 1'b1);
    endtask

    task automatic t_lcarry;
        load(mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 1, 2'd3), 2'b00);
        cin = 1'b1; cpt = 2'b10; #1 chk("R12 carry only", mc_out, 1'b1);
        pt = 16'h0001; #1 chk("R12 sum^carry", mc_out, 1'b0);
        cpt = 2'b00; #1 chk("R12 sum only", mc_out, 1'b1);
    endtask

    task automatic t_static;
        load(mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 2'd1), 2'b00);
        chk("R13 initial", mc_out, 1'b1);
        cfg_i = mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 2'd0);
        repeat (3) @(negedge clk);
        chk("R13 live change ignored", mc_out, 1'b1);
        load(mk(16'hFFFF, 1, 0, 0, 0, 0, 0, 0, 2'd0), 2'b00);
        chk("R13 new word after reset", mc_out, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_sum();
        t_outmux();
        t_clksrc();
        t_edge();
        t_async();
        t_inv();
        t_xor();
        t_toggle();
        t_carry();
        t_lcarry();
        t_static();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule